// File: doc/BRIEF.md
# Narrow-Wide AXI Channel Mapper

This block sits at the manager side of a network interface. It connects two AXI managers, one narrow and one wide, to three separate physical network links: a request link, a response link and a wide link. Outgoing address and write-data beats are packed into flits, and each flit carries a 3-bit type code in its low bits. Incoming flits are decoded from the same type field and passed to the matching read-data or write-response port.

Request-side traffic goes to the request link. This covers narrow write addresses, narrow read addresses, narrow write data and wide read addresses. Wide write addresses share the wide link with wide write data, so an address can never be overtaken by the data beats that follow it. Four sources compete for the request link and two compete for the wide link. Each link has its own round-robin arbiter. Once a flit has been offered, the arbiter holds it until the link accepts it.

Every flit on a link has the same width. A payload shorter than the link's payload field is zero-padded above its own bits. Every port uses valid-ready handshaking. An inbound flit whose type code is not valid for its link is consumed and discarded, and a sticky error flag is raised.

Top module: `nw_chan_mapper`

## Requirements
- R1: A flit on the request link carries the type code in bits [2:0] and the payload zero-extended from bit 3 upward. The codes are: narrow write address 0, narrow read address 1, narrow write data 2, wide read address 3.
- R2: A flit on the wide outbound link uses the same layout. The codes are: wide write address 4, wide write data 5.
- R3: At most one request-link source and at most one wide-link source sees ready in a cycle. A source sees ready only when it is the selected one and its link's ready is high.
- R4: The request link arbitrates round-robin in source order: narrow write address, narrow read address, narrow write data, wide read address. Straight after reset, with all four sources valid, they are granted in that order. A source that stays valid waits for no more than three grants to other sources.
- R5: The wide outbound link alternates between its two sources, write address first after reset. A source that stays valid waits for no more than one grant to the other source.
- R6: A flit that is offered but not accepted stays valid and unchanged in the next cycle.
- R7: On the response link, code 2 is routed to narrow read data (payload bits [66:3]), code 0 to narrow write response, and code 7 to wide write response (payload bits [4:3]). The response link's ready follows the ready of the selected port.
- R8: On the wide inbound link, code 6 is routed to wide read data (payload from bit 3 upward), and the link's ready follows that port's ready.
- R9: An inbound flit with any other code is accepted at once and reaches no output port. The error flag is high from the next cycle on and stays high until reset.
- R10: Reset clears the error flag and returns both arbiters to their first source. With no source valid, neither outbound link is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| narAwValid | input | 1 | Narrow write address valid |
| narAwReady | output | 1 | Narrow write address ready |
| narAwAddr | input | AddrW | Narrow write address |
| narArValid | input | 1 | Narrow read address valid |
| narArReady | output | 1 | Narrow read address ready |
| narArAddr | input | AddrW | Narrow read address |
| narWValid | input | 1 | Narrow write data valid |
| narWReady | output | 1 | Narrow write data ready |
| narWData | input | NarrowDataW | Narrow write data |
| wideArValid | input | 1 | Wide read address valid |
| wideArReady | output | 1 | Wide read address ready |
| wideArAddr | input | AddrW | Wide read address |
| wideAwValid | input | 1 | Wide write address valid |
| wideAwReady | output | 1 | Wide write address ready |
| wideAwAddr | input | AddrW | Wide write address |
| wideWValid | input | 1 | Wide write data valid |
| wideWReady | output | 1 | Wide write data ready |
| wideWData | input | WideDataW | Wide write data |
| narRValid | output | 1 | Narrow read data valid |
| narRReady | input | 1 | Narrow read data ready |
| narRData | output | NarrowDataW | Narrow read data |
| narBValid | output | 1 | Narrow write response valid |
| narBReady | input | 1 | Narrow write response ready |
| narBResp | output | RespW | Narrow write response |
| wideRValid | output | 1 | Wide read data valid |
| wideRReady | input | 1 | Wide read data ready |
| wideRData | output | WideDataW | Wide read data |
| wideBValid | output | 1 | Wide write response valid |
| wideBReady | input | 1 | Wide write response ready |
| wideBResp | output | RespW | Wide write response |
| reqValid | output | 1 | Request link valid |
| reqReady | input | 1 | Request link ready |
| reqFlit | output | ReqFlitW | Request link flit |
| wideTxValid | output | 1 | Wide outbound link valid |
| wideTxReady | input | 1 | Wide outbound link ready |
| wideTxFlit | output | WideFlitW | Wide outbound link flit |
| rspValid | input | 1 | Response link valid |
| rspReady | output | 1 | Response link ready |
| rspFlit | input | RspFlitW | Response link flit |
| wideRxValid | input | 1 | Wide inbound link valid |
| wideRxReady | output | 1 | Wide inbound link ready |
| wideRxFlit | input | WideFlitW | Wide inbound link flit |
| errFlag | output | 1 | Sticky flag for a discarded inbound flit |

## Verification
The hold and single-ready properties assume that every outbound AXI source keeps its valid signal and payload steady from the moment it raises valid until its handshake. Without that, a held grant could point at a source that has withdrawn. The stimulus follows this rule: it draws a new valid or payload for a source only when that source is idle or has just been accepted. The inbound decode is purely combinational, so the stimulus may change inbound flits freely in every cycle. Random phases first use only legal inbound codes, which keeps the error flag low, and later allow every code.

// File: rtl/nwm_pkg.sv
package nwm_pkg;
  localparam int TypeW = 3;

  typedef enum logic [TypeW-1:0] {
    TNarrowAw = 3'd0,
    TNarrowAr = 3'd1,
    TNarrowW  = 3'd2,
    TWideAr   = 3'd3,
    TWideAw   = 3'd4,
    TWideW    = 3'd5,
    TWideR    = 3'd6,
    TWideB    = 3'd7
  } flit_type_e;

  // Codes reused on the response link
  localparam logic [TypeW-1:0] TNarrowR = 3'd2;
  localparam logic [TypeW-1:0] TNarrowB = 3'd0;

  localparam int ReqSrcN  = 4;
  localparam int WideSrcN = 2;

  // Strobes from control to datapath: one-hot source selects
  typedef struct packed {
    logic [ReqSrcN-1:0]  reqGnt;
    logic [WideSrcN-1:0] wideGnt;
  } strobe_t;
endpackage

// File: rtl/nwm_rr_arb.sv
module nwm_rr_arb #(
  parameter int N = 4,
  localparam int IdxW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic         outReady,
  output logic [N-1:0] gnt,
  output logic         outValid
);
  logic [IdxW-1:0] ptrQ, pickIdx, heldIdxQ, gntIdx;
  logic [N-1:0]    pick, heldQ;
  logic            holdQ, found;

  always_comb begin
    pick    = '0;
    pickIdx = ptrQ;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      automatic logic [IdxW-1:0] idx = IdxW'((int'(ptrQ) + k) % N);
      if (!found && req[idx]) begin
        pick[idx] = 1'b1;
        pickIdx   = idx;
        found     = 1'b1;
      end
    end
  end

  assign gnt      = holdQ ? heldQ : pick;
  assign gntIdx   = holdQ ? heldIdxQ : pickIdx;
  assign outValid = |(gnt & req);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ     <= '0;
      holdQ    <= 1'b0;
      heldQ    <= '0;
      heldIdxQ <= '0;
    end else if (outValid && outReady) begin
      holdQ <= 1'b0;
      ptrQ  <= (gntIdx == IdxW'(N - 1)) ? '0 : gntIdx + 1'b1;
    end else if (outValid) begin
      holdQ    <= 1'b1;
      heldQ    <= gnt;
      heldIdxQ <= gntIdx;
    end
  end
endmodule

// File: rtl/nwm_ctrl.sv
module nwm_ctrl import nwm_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ReqSrcN-1:0]  reqSrcValid,
  input  logic                reqReady,
  output logic                reqValid,
  output logic [ReqSrcN-1:0]  reqSrcReady,
  input  logic [WideSrcN-1:0] wideSrcValid,
  input  logic                wideTxReady,
  output logic                wideTxValid,
  output logic [WideSrcN-1:0] wideSrcReady,
  input  logic                rspValid,
  input  logic [TypeW-1:0]    rspType,
  input  logic [2:0]          rspTgtReady,
  output logic                rspReady,
  output logic [2:0]          rspTgtValid,
  input  logic                wideRxValid,
  input  logic [TypeW-1:0]    wideRxType,
  input  logic                wideRReady,
  output logic                wideRxReady,
  output logic                wideRValid,
  output strobe_t             strb,
  output logic                errFlag
);
  logic [ReqSrcN-1:0]  reqGnt;
  logic [WideSrcN-1:0] wideGnt;
  logic [2:0]          rspRoute;
  logic                wideRoute, rspBad, wideBad, errQ;

  nwm_rr_arb #(.N(ReqSrcN)) reqArb (
    .clk, .rstN, .req(reqSrcValid), .outReady(reqReady),
    .gnt(reqGnt), .outValid(reqValid)
  );

  nwm_rr_arb #(.N(WideSrcN)) wideArb (
    .clk, .rstN, .req(wideSrcValid), .outReady(wideTxReady),
    .gnt(wideGnt), .outValid(wideTxValid)
  );

  assign strb         = '{reqGnt: reqGnt, wideGnt: wideGnt};
  assign reqSrcReady  = reqGnt & {ReqSrcN{reqReady}};
  assign wideSrcReady = wideGnt & {WideSrcN{wideTxReady}};

  // Generic header view: decode the type before the payload is used
  assign rspRoute[0] = (rspType == TNarrowR);
  assign rspRoute[1] = (rspType == TNarrowB);
  assign rspRoute[2] = (rspType == TWideB);
  assign rspTgtValid = rspRoute & {3{rspValid}};
  assign rspReady    = (rspRoute == '0) ? 1'b1 : |(rspRoute & rspTgtReady);
  assign rspBad      = rspValid && (rspRoute == '0);

  assign wideRoute   = (wideRxType == TWideR);
  assign wideRValid  = wideRxValid && wideRoute;
  assign wideRxReady = wideRoute ? wideRReady : 1'b1;
  assign wideBad     = wideRxValid && !wideRoute;

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= errQ | rspBad | wideBad;
  end
  assign errFlag = errQ;

  // R3
  one_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqSrcReady) && $onehot0(wideSrcReady));
  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqSrcReady & ~reqSrcValid) == '0) && ((wideSrcReady & ~wideSrcValid) == '0));
  // R9
  drop_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTgtValid == '0) |-> rspReady);
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rspValid && rspTgtValid == '0) || (wideRxValid && !wideRValid)) |=> errFlag);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/nwm_dp.sv
module nwm_dp import nwm_pkg::*; #(
  parameter int AddrW       = 32,
  parameter int NarrowDataW = 64,
  parameter int WideDataW   = 512,
  parameter int RespW       = 2,
  parameter int ReqFlitW    = 67,
  parameter int RspFlitW    = 67,
  parameter int WideFlitW   = 515
) (
  input  strobe_t                strb,
  input  logic [AddrW-1:0]       narAwAddr,
  input  logic [AddrW-1:0]       narArAddr,
  input  logic [NarrowDataW-1:0] narWData,
  input  logic [AddrW-1:0]       wideArAddr,
  input  logic [AddrW-1:0]       wideAwAddr,
  input  logic [WideDataW-1:0]   wideWData,
  input  logic [RspFlitW-1:0]    rspFlit,
  input  logic [WideFlitW-1:0]   wideRxFlit,
  output logic [ReqFlitW-1:0]    reqFlit,
  output logic [WideFlitW-1:0]   wideTxFlit,
  output logic [NarrowDataW-1:0] narRData,
  output logic [RespW-1:0]       narBResp,
  output logic [RespW-1:0]       wideBResp,
  output logic [WideDataW-1:0]   wideRData
);
  localparam int ReqPayW  = ReqFlitW - TypeW;
  localparam int WidePayW = WideFlitW - TypeW;

  logic [ReqPayW-1:0]  reqPay;
  logic [WidePayW-1:0] widePay;
  flit_type_e          reqCode, wideCode;

  always_comb begin
    reqPay  = '0;
    reqCode = TNarrowAw;
    if (strb.reqGnt[0]) begin reqPay = ReqPayW'(narAwAddr);  reqCode = TNarrowAw; end
    if (strb.reqGnt[1]) begin reqPay = ReqPayW'(narArAddr);  reqCode = TNarrowAr; end
    if (strb.reqGnt[2]) begin reqPay = ReqPayW'(narWData);   reqCode = TNarrowW;  end
    if (strb.reqGnt[3]) begin reqPay = ReqPayW'(wideArAddr); reqCode = TWideAr;   end
  end

  always_comb begin
    widePay  = '0;
    wideCode = TWideAw;
    if (strb.wideGnt[0]) begin widePay = WidePayW'(wideAwAddr); wideCode = TWideAw; end
    if (strb.wideGnt[1]) begin widePay = WidePayW'(wideWData);  wideCode = TWideW;  end
  end

  assign reqFlit    = {reqPay, reqCode};
  assign wideTxFlit = {widePay, wideCode};

  assign narRData  = rspFlit[TypeW +: NarrowDataW];
  assign narBResp  = rspFlit[TypeW +: RespW];
  assign wideBResp = rspFlit[TypeW +: RespW];
  assign wideRData = wideRxFlit[TypeW +: WideDataW];
endmodule

// File: rtl/nw_chan_mapper.sv
module nw_chan_mapper import nwm_pkg::*; #(
  parameter int AddrW       = 32,
  parameter int NarrowDataW = 64,
  parameter int WideDataW   = 512,
  parameter int RespW       = 2,
  localparam int ReqFlitW   = ((AddrW > NarrowDataW) ? AddrW : NarrowDataW) + TypeW,
  localparam int RspFlitW   = ((NarrowDataW > RespW) ? NarrowDataW : RespW) + TypeW,
  localparam int WideFlitW  = ((WideDataW > AddrW) ? WideDataW : AddrW) + TypeW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   narAwValid,
  output logic                   narAwReady,
  input  logic [AddrW-1:0]       narAwAddr,
  input  logic                   narArValid,
  output logic                   narArReady,
  input  logic [AddrW-1:0]       narArAddr,
  input  logic                   narWValid,
  output logic                   narWReady,
  input  logic [NarrowDataW-1:0] narWData,
  input  logic                   wideArValid,
  output logic                   wideArReady,
  input  logic [AddrW-1:0]       wideArAddr,
  input  logic                   wideAwValid,
  output logic                   wideAwReady,
  input  logic [AddrW-1:0]       wideAwAddr,
  input  logic                   wideWValid,
  output logic                   wideWReady,
  input  logic [WideDataW-1:0]   wideWData,
  output logic                   narRValid,
  input  logic                   narRReady,
  output logic [NarrowDataW-1:0] narRData,
  output logic                   narBValid,
  input  logic                   narBReady,
  output logic [RespW-1:0]       narBResp,
  output logic                   wideRValid,
  input  logic                   wideRReady,
  output logic [WideDataW-1:0]   wideRData,
  output logic                   wideBValid,
  input  logic                   wideBReady,
  output logic [RespW-1:0]       wideBResp,
  output logic                   reqValid,
  input  logic                   reqReady,
  output logic [ReqFlitW-1:0]    reqFlit,
  output logic                   wideTxValid,
  input  logic                   wideTxReady,
  output logic [WideFlitW-1:0]   wideTxFlit,
  input  logic                   rspValid,
  output logic                   rspReady,
  input  logic [RspFlitW-1:0]    rspFlit,
  input  logic                   wideRxValid,
  output logic                   wideRxReady,
  input  logic [WideFlitW-1:0]   wideRxFlit,
  output logic                   errFlag
);
  strobe_t             strb;
  logic [ReqSrcN-1:0]  reqSrcReady;
  logic [WideSrcN-1:0] wideSrcReady;
  logic [2:0]          rspTgtValid;

  nwm_ctrl ctrl_i (
    .clk, .rstN,
    .reqSrcValid({wideArValid, narWValid, narArValid, narAwValid}),
    .reqReady, .reqValid, .reqSrcReady,
    .wideSrcValid({wideWValid, wideAwValid}),
    .wideTxReady, .wideTxValid, .wideSrcReady,
    .rspValid, .rspType(rspFlit[TypeW-1:0]),
    .rspTgtReady({wideBReady, narBReady, narRReady}),
    .rspReady, .rspTgtValid,
    .wideRxValid, .wideRxType(wideRxFlit[TypeW-1:0]),
    .wideRReady, .wideRxReady, .wideRValid,
    .strb, .errFlag
  );

  nwm_dp #(
    .AddrW(AddrW), .NarrowDataW(NarrowDataW), .WideDataW(WideDataW), .RespW(RespW),
    .ReqFlitW(ReqFlitW), .RspFlitW(RspFlitW), .WideFlitW(WideFlitW)
  ) dp_i (
    .strb, .narAwAddr, .narArAddr, .narWData, .wideArAddr, .wideAwAddr, .wideWData,
    .rspFlit, .wideRxFlit, .reqFlit, .wideTxFlit,
    .narRData, .narBResp, .wideBResp, .wideRData
  );

  assign {wideArReady, narWReady, narArReady, narAwReady} = reqSrcReady;
  assign {wideWReady, wideAwReady}                        = wideSrcReady;
  assign {wideBValid, narBValid, narRValid}               = rspTgtValid;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqFlit)));
  // R6
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wideTxValid && !wideTxReady) |=> (wideTxValid && $stable(wideTxFlit)));
  // R7
  narr_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFlit[TypeW-1:0] == TNarrowR) |-> (narRValid && rspReady == narRReady));
  // R8
  wide_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wideRxValid && wideRxFlit[TypeW-1:0] == TWideR) |-> (wideRValid && wideRxReady == wideRReady));
endmodule

// File: tb/nw_chan_mapper_tb_top.sv
`timescale 1ns/100ps
module nw_chan_mapper_tb_top;
  localparam int ReqFlitW  = 67;
  localparam int RspFlitW  = 67;
  localparam int WideFlitW = 515;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [3:0]   rqV = '0;
  logic [63:0]  rqD [4];
  logic [1:0]   wdV = '0;
  logic [511:0] wdD [2];
  logic [3:0]   rqRdy;
  logic [1:0]   wdRdy;
  logic reqReady = 1'b0, wideTxReady = 1'b0;
  logic reqValid, wideTxValid;
  logic [ReqFlitW-1:0]  reqFlit;
  logic [WideFlitW-1:0] wideTxFlit;
  logic rspValid = 1'b0, wideRxValid = 1'b0;
  logic [RspFlitW-1:0]  rspFlit = '0;
  logic [WideFlitW-1:0] wideRxFlit = '0;
  logic rspReady, wideRxReady;
  logic narRReady = 1'b0, narBReady = 1'b0, wideBReady = 1'b0, wideRReady = 1'b0;
  logic narRValid, narBValid, wideBValid, wideRValid;
  logic [63:0]  narRData;
  logic [1:0]   narBResp, wideBResp;
  logic [511:0] wideRData;
  logic errFlag;

  nw_chan_mapper dut_i (
    .clk, .rstN,
    .narAwValid(rqV[0]), .narAwReady(rqRdy[0]), .narAwAddr(rqD[0][31:0]),
    .narArValid(rqV[1]), .narArReady(rqRdy[1]), .narArAddr(rqD[1][31:0]),
    .narWValid(rqV[2]),  .narWReady(rqRdy[2]),  .narWData(rqD[2]),
    .wideArValid(rqV[3]), .wideArReady(rqRdy[3]), .wideArAddr(rqD[3][31:0]),
    .wideAwValid(wdV[0]), .wideAwReady(wdRdy[0]), .wideAwAddr(wdD[0][31:0]),
    .wideWValid(wdV[1]),  .wideWReady(wdRdy[1]),  .wideWData(wdD[1]),
    .narRValid, .narRReady, .narRData,
    .narBValid, .narBReady, .narBResp,
    .wideRValid, .wideRReady, .wideRData,
    .wideBValid, .wideBReady, .wideBResp,
    .reqValid, .reqReady, .reqFlit,
    .wideTxValid, .wideTxReady, .wideTxFlit,
    .rspValid, .rspReady, .rspFlit,
    .wideRxValid, .wideRxReady, .wideRxFlit,
    .errFlag
  );

  // Bench state
  int mode = 0;           // 0 drain, 1 directed all-valid, 2 random
  bit allowBad = 1'b0;
  bit expErr = 1'b0;
  int rrCnt = 0, rrCntW = 0;
  int waitR [4];
  int waitW [2];
  bit stallReq = 1'b0, stallWide = 1'b0;
  logic [ReqFlitW-1:0]  prevReq;
  logic [WideFlitW-1:0] prevWide;
  logic [3:0] accR;
  logic [1:0] accW;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [WideFlitW-1:0] act, input logic [WideFlitW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ReqFlitW-1:0] expReq(input int i, input logic [63:0] d);
    return {d, 3'(i)};
  endfunction

  function automatic logic [WideFlitW-1:0] expWide(input int i, input logic [511:0] d);
    return {d, 3'(4 + i)};
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [63:0] newReqData(input int i);
    return (i == 2) ? {$urandom, $urandom} : {32'h0, $urandom};
  endfunction

  function automatic logic [511:0] newWideData(input int i);
    return (i == 1) ? rand512() : {480'h0, $urandom};
  endfunction

  // Checks made at the falling edge
  task automatic negCheck();
    int gi;
    logic [2:0] expRoute;
    logic [2:0] code;
    @(negedge clk);
    // R3: single ready per link, only with link ready
    chk($countones(rqRdy) <= 1 && (rqRdy == 0 || reqReady), "R3", "req readies", rqRdy, 0);
    chk($countones(wdRdy) <= 1 && (wdRdy == 0 || wideTxReady), "R3", "wide readies", wdRdy, 0);
    accR = rqRdy & rqV;
    accW = wdRdy & wdV;
    // R6: offered flit unchanged
    if (stallReq) chk(reqValid && reqFlit == prevReq, "R6", "req hold", reqFlit, prevReq);
    if (stallWide) chk(wideTxValid && wideTxFlit == prevWide, "R6", "wide hold", wideTxFlit, prevWide);
    stallReq = reqValid && !reqReady;  prevReq = reqFlit;
    stallWide = wideTxValid && !wideTxReady; prevWide = wideTxFlit;
    if (reqValid && reqReady) begin
      gi = -1;
      for (int i = 0; i < 4; i++) if (rqRdy[i]) gi = i;
      chk(gi >= 0 && reqFlit == expReq(gi, rqD[gi]), "R1", "req flit", reqFlit,
          gi >= 0 ? expReq(gi, rqD[gi]) : '0);
      for (int i = 0; i < 4; i++) begin
        if (i == gi) waitR[i] = 0;
        else if (rqV[i]) begin
          waitR[i]++;
          if (waitR[i] > 3) chk(1'b0, "R4", "starvation", waitR[i], 3);
        end
      end
      if (mode == 1) begin
        chk(gi == rrCnt % 4, "R4", "round-robin order", gi, rrCnt % 4);
        rrCnt++;
      end
    end
    if (wideTxValid && wideTxReady) begin
      gi = -1;
      for (int i = 0; i < 2; i++) if (wdRdy[i]) gi = i;
      chk(gi >= 0 && wideTxFlit == expWide(gi, wdD[gi]), "R2", "wide flit", wideTxFlit,
          gi >= 0 ? expWide(gi, wdD[gi]) : '0);
      for (int i = 0; i < 2; i++) begin
        if (i == gi) waitW[i] = 0;
        else if (wdV[i]) begin
          waitW[i]++;
          if (waitW[i] > 1) chk(1'b0, "R5", "starvation", waitW[i], 1);
        end
      end
      if (mode == 1) begin
        chk(gi == rrCntW % 2, "R5", "alternation", gi, rrCntW % 2);
        rrCntW++;
      end
    end
    // Error flag reflects drops seen before the last edge
    chk(errFlag == expErr, "R9", "error flag", errFlag, expErr);
    // R7 / R9 response link
    code = rspFlit[2:0];
    expRoute = !rspValid ? 3'b000 : (code == 3'd2) ? 3'b001 : (code == 3'd0) ? 3'b010 :
               (code == 3'd7) ? 3'b100 : 3'b000;
    chk({wideBValid, narBValid, narRValid} == expRoute, "R7", "rsp route",
        {wideBValid, narBValid, narRValid}, expRoute);
    if (rspValid && expRoute == 3'b000) begin
      chk(rspReady == 1'b1, "R9", "drop ready", rspReady, 1);
      expErr = 1'b1;
    end else if (rspValid) begin
      chk(rspReady == |(expRoute & {wideBReady, narBReady, narRReady}), "R7", "rsp ready",
          rspReady, |(expRoute & {wideBReady, narBReady, narRReady}));
      if (expRoute[0]) chk(narRData == rspFlit[66:3], "R7", "narrow R data", narRData, rspFlit[66:3]);
      if (expRoute[1]) chk(narBResp == rspFlit[4:3], "R7", "narrow B resp", narBResp, rspFlit[4:3]);
      if (expRoute[2]) chk(wideBResp == rspFlit[4:3], "R7", "wide B resp", wideBResp, rspFlit[4:3]);
    end
    // R8 / R9 wide inbound link
    if (wideRxValid && wideRxFlit[2:0] == 3'd6) begin
      chk(wideRValid && wideRxReady == wideRReady && wideRData == wideRxFlit[514:3], "R8",
          "wide R route", wideRData, wideRxFlit[514:3]);
    end else begin
      chk(!wideRValid, "R9", "wide inbound no output", wideRValid, 0);
      if (wideRxValid) begin
        chk(wideRxReady == 1'b1, "R9", "wide drop ready", wideRxReady, 1);
        expErr = 1'b1;
      end
    end
  endtask

  task automatic drive();
    @(posedge clk);
    #0.5;
    for (int i = 0; i < 4; i++) begin
      if (accR[i] || !rqV[i]) begin
        if (mode == 1) begin rqV[i] = 1'b1; rqD[i] = newReqData(i); end
        else if (mode == 2) begin rqV[i] = $urandom % 2; rqD[i] = newReqData(i); end
        else rqV[i] = 1'b0;
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (accW[i] || !wdV[i]) begin
        if (mode == 1) begin wdV[i] = 1'b1; wdD[i] = newWideData(i); end
        else if (mode == 2) begin wdV[i] = $urandom % 2; wdD[i] = newWideData(i); end
        else wdV[i] = 1'b0;
      end
    end
    accR = '0;
    accW = '0;
    reqReady    = (mode == 2) ? ($urandom % 4 != 0) : 1'b1;
    wideTxReady = (mode == 2) ? ($urandom % 4 != 0) : 1'b1;
    if (mode == 2) begin
      int pick;
      logic [2:0] rc;
      logic [2:0] wc;
      pick = $urandom % 3;
      rc = allowBad ? 3'($urandom) : (pick == 0 ? 3'd0 : pick == 1 ? 3'd2 : 3'd7);
      wc = allowBad ? 3'($urandom) : 3'd6;
      rspValid    = $urandom % 2;
      rspFlit     = {$urandom, $urandom, rc};
      wideRxValid = $urandom % 2;
      wideRxFlit  = {rand512(), wc};
      narRReady   = $urandom % 2;
      narBReady   = $urandom % 2;
      wideBReady  = $urandom % 2;
      wideRReady  = $urandom % 2;
    end else begin
      rspValid    = 1'b0;
      wideRxValid = 1'b0;
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      negCheck();
      drive();
    end
  endtask

  task automatic doReset();
    mode = 0;
    rstN = 1'b0;
    rqV = '0; wdV = '0; accR = '0; accW = '0;
    rspValid = 1'b0; wideRxValid = 1'b0;
    repeat (3) @(posedge clk);
    #0.5;
    rstN = 1'b1;
    expErr = 1'b0; stallReq = 1'b0; stallWide = 1'b0;
    rrCnt = 0; rrCntW = 0;
    for (int i = 0; i < 4; i++) waitR[i] = 0;
    for (int i = 0; i < 2; i++) waitW[i] = 0;
    @(negedge clk);
    // R10: reset state
    chk(errFlag == 1'b0, "R10", "error flag after reset", errFlag, 0);
    chk(!reqValid && !wideTxValid, "R10", "links idle after reset", {reqValid, wideTxValid}, 0);
    @(posedge clk);
    #0.5;
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 4; i++) rqD[i] = '0;
    for (int i = 0; i < 2; i++) wdD[i] = '0;
    doReset();
    // R4/R5 directed order right after reset
    mode = 1; step(14);
    mode = 0; step(6);
    // Random traffic with legal inbound codes only
    mode = 2; allowBad = 1'b0; step(3000);
    mode = 0; step(6);
    // Directed drop on the response link (R9)
    rspValid = 1'b1; rspFlit = {64'hfeed_beef_0bad_cafe, 3'd5};
    narRReady = 1'b0; narBReady = 1'b0; wideBReady = 1'b0;
    step(1);
    step(6);
    chk(errFlag == 1'b1, "R9", "sticky after drop", errFlag, 1);
    // R10: reset clears the flag and restarts the arbiters
    doReset();
    mode = 1; step(10);
    mode = 0; step(4);
    // Directed drop on the wide inbound link (R9)
    wideRxValid = 1'b1; wideRxFlit = {512'h5a, 3'd4}; wideRReady = 1'b0;
    step(1);
    step(4);
    chk(errFlag == 1'b1, "R9", "wide drop sets flag", errFlag, 1);
    // Random traffic with every inbound code
    mode = 2; allowBad = 1'b1; step(3000);
    mode = 0; step(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule